// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

This block resolves conditional branches for a five-stage in-order pipeline that has one architectural delay slot. In the branch's execute cycle it receives the condition kind, the source register indices, the register-read values, a 16-bit word offset and the branch's own PC. For each operand it picks either the register-read value or the ALU result of the instruction just ahead, so a branch can test a value computed one instruction earlier. From these it decides taken or not taken and forms the target address, all in the same cycle.

The block owns the fetch program counter. The delay-slot instruction is assumed to be the fetch in flight while the branch resolves. A taken decision therefore loads the target straight into the fetch PC at the next edge, so the order is branch, delay slot, target, with no squash and no bubble. The block never asks the pipeline to stall. It has no stall output. The PC path uses plain control pins and has no valid/ready handshake, because the unit can never hold back the pipeline.

Top module: `brx_resolve_unit`

## Requirements
- R1: While reset is held and right after it is released, `fetch_pc` equals parameter `RESET_VEC` and `redirect` is 0.
- R2: In a cycle where `br_taken` is 0, including every cycle with `ex_valid` low, `fetch_pc` advances by 4 at the next edge and `redirect` is 0 after that edge.
- R3: `ex_cond` 3'd0 (equal) is taken when the two resolved operands match, and 3'd1 (not equal) is taken when they differ.
- R4: The single-operand tests use the resolved first operand only and ignore the second. Code 3'd2 is taken when the value is below zero (sign bit set). Code 3'd3 is taken when the value is zero or above. Code 3'd4 is taken when the sign bit is set or the value is zero. Code 3'd5 is taken when the sign bit is clear and the value is non-zero.
- R5: `ex_cond` codes 3'd6 and 3'd7 are never taken.
- R6: `br_target` equals `ex_pc` + 4 + (sign-extended `ex_offset` shifted left by 2), for both positive and negative offsets.
- R7: After an edge where `br_taken` was 1, `fetch_pc` equals the target sampled at that edge and `redirect` is 1. `redirect` stays 1 only for cycles that follow a taken decision.
- R8: An operand takes `prev_result` instead of its register-read value when `prev_wr_en` is 1 and `prev_rd` equals that operand's non-zero source index. Otherwise it takes the register-read value.
- R9: A source index of 0 always resolves to zero, whatever the register-read value or the bypass inputs are.
- R10: `br_taken` and `br_target` are combinational in the same cycle as the inputs, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | A conditional branch occupies execute this cycle |
| ex_cond | input | 3 | Condition kind (codes in R3 to R5) |
| ex_pc | input | 32 | Address of the branch instruction |
| ex_offset | input | 16 | Signed word offset |
| ex_rs | input | 5 | First source register index |
| ex_rt | input | 5 | Second source register index |
| rs_rf_data | input | 32 | Register-read value of the first source |
| rt_rf_data | input | 32 | Register-read value of the second source |
| prev_wr_en | input | 1 | Previous instruction writes a register |
| prev_rd | input | 5 | Destination index of the previous instruction |
| prev_result | input | 32 | ALU result of the previous instruction |
| br_taken | output | 1 | Branch decision this cycle |
| br_target | output | 32 | Computed target this cycle |
| fetch_pc | output | 32 | Registered fetch address |
| redirect | output | 1 | Fetch PC was loaded from a target at the last edge |

## Verification
The bench targets the bypass corners. It tests a branch whose operand was produced one instruction earlier while the register-read value disagrees in sign. A unit that skipped the bypass would branch the wrong way. It also sets the previous destination to register 0, and a design that bypassed there would treat register 0 as non-zero. Zero-valued operands separate the four sign/zero tests, so a swapped or off-by-equality condition flips the result. Back-to-back taken branches and a negative offset check that the target adds to the delay-slot address and that the fetch PC does not add an extra 4 or hold the target for two cycles.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [2:0] {
    COND_EQ   = 3'd0,
    COND_NE   = 3'd1,
    COND_LTZ  = 3'd2,
    COND_GEZ  = 3'd3,
    COND_LEZ  = 3'd4,
    COND_GTZ  = 3'd5,
    COND_RSV6 = 3'd6,
    COND_RSV7 = 3'd7
  } cond_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/brx_operand_sel.sv
module brx_operand_sel #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5
) (
  input  logic [RAW-1:0]  src_idx,
  input  logic [XLEN-1:0] rf_data,
  input  logic            prev_wr_en,
  input  logic [RAW-1:0]  prev_rd,
  input  logic [XLEN-1:0] prev_result,
  output logic [XLEN-1:0] opnd
);
  logic src_is_zero;
  logic hit;

  always_comb begin
    src_is_zero = (src_idx == '0);
    hit         = prev_wr_en && (prev_rd != '0) && (prev_rd == src_idx);
    if (src_is_zero)
      opnd = '0;
    else if (hit)
      opnd = prev_result;
    else
      opnd = rf_data;
  end
endmodule

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
  import brx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            valid,
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  cond_e kind;
  logic  a_neg;
  logic  a_zero;
  logic  same;
  logic  hit;

  always_comb begin
    kind   = cond_e'(cond);
    a_neg  = opa[XLEN-1];
    a_zero = (opa == '0);
    same   = (opa == opb);
    unique case (kind)
      COND_EQ:  hit = same;
      COND_NE:  hit = !same;
      COND_LTZ: hit = a_neg;
      COND_GEZ: hit = !a_neg;
      COND_LEZ: hit = a_neg || a_zero;
      COND_GTZ: hit = !a_neg && !a_zero;
      default:  hit = 1'b0;
    endcase
    taken = valid && hit;
  end
endmodule

// File: rtl/brx_target_gen.sv
module brx_target_gen #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFFW = 16
) (
  input  logic [XLEN-1:0] pc,
  input  logic [OFFW-1:0] offset,
  output logic [XLEN-1:0] target
);
  localparam int unsigned SHIFT = 2;
  localparam int unsigned EXTW  = XLEN - OFFW - SHIFT;
  localparam logic [XLEN-1:0] STEP = XLEN'(brx_pkg::INSN_BYTES);

  logic [XLEN-1:0] byte_off;
  logic [XLEN-1:0] slot_pc;

  always_comb begin
    byte_off = {{EXTW{offset[OFFW-1]}}, offset, {SHIFT{1'b0}}};
    slot_pc  = pc + STEP;
    target   = slot_pc + byte_off;
  end
endmodule

// File: rtl/brx_resolve_unit.sv
module brx_resolve_unit #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned RAW       = 5,
  parameter int unsigned OFFW      = 16,
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic [2:0]      ex_cond,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [OFFW-1:0] ex_offset,
  input  logic [RAW-1:0]  ex_rs,
  input  logic [RAW-1:0]  ex_rt,
  input  logic [XLEN-1:0] rs_rf_data,
  input  logic [XLEN-1:0] rt_rf_data,
  input  logic            prev_wr_en,
  input  logic [RAW-1:0]  prev_rd,
  input  logic [XLEN-1:0] prev_result,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic [XLEN-1:0] fetch_pc,
  output logic            redirect
);
  localparam int unsigned NOPND = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(brx_pkg::INSN_BYTES);

  logic [RAW-1:0]  src_idx [NOPND];
  logic [XLEN-1:0] src_rf  [NOPND];
  logic [XLEN-1:0] opnd    [NOPND];

  assign src_idx[0] = ex_rs;
  assign src_idx[1] = ex_rt;
  assign src_rf[0]  = rs_rf_data;
  assign src_rf[1]  = rt_rf_data;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    brx_operand_sel #(.XLEN(XLEN), .RAW(RAW)) u_sel (
      .src_idx    (src_idx[g]),
      .rf_data    (src_rf[g]),
      .prev_wr_en (prev_wr_en),
      .prev_rd    (prev_rd),
      .prev_result(prev_result),
      .opnd       (opnd[g])
    );
  end

  brx_cond_eval #(.XLEN(XLEN)) u_eval (
    .valid (ex_valid),
    .cond  (ex_cond),
    .opa   (opnd[0]),
    .opb   (opnd[1]),
    .taken (br_taken)
  );

  brx_target_gen #(.XLEN(XLEN), .OFFW(OFFW)) u_tgt (
    .pc     (ex_pc),
    .offset (ex_offset),
    .target (br_target)
  );

  logic [XLEN-1:0] pc_next;

  always_comb begin
    pc_next = br_taken ? br_target : (fetch_pc + STEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= XLEN'(RESET_VEC);
      redirect <= 1'b0;
    end else begin
      fetch_pc <= pc_next;
      redirect <= br_taken;
    end
  end
endmodule

// File: rtl/brx_resolve_chk.sv
module brx_resolve_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ex_valid,
  input logic [2:0]      ex_cond,
  input logic [RAW-1:0]  ex_rs,
  input logic [RAW-1:0]  ex_rt,
  input logic            br_taken,
  input logic [XLEN-1:0] br_target,
  input logic [XLEN-1:0] fetch_pc,
  input logic            redirect
);
  // R7
  taken_loads_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (fetch_pc == $past(br_target)) && redirect);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> (fetch_pc == $past(fetch_pc) + XLEN'(4)) && !redirect);

  // R2
  idle_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> !br_taken);

  // R5
  reserved_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_cond[2:1] == 2'b11) |-> !br_taken);

  // R9
  zero_regs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_cond == 3'd0 && ex_rs == '0 && ex_rt == '0) |-> br_taken);

  // R9
  zero_reg_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_cond == 3'd2 && ex_rs == '0) |-> !br_taken);
endmodule

bind brx_resolve_unit brx_resolve_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ex_valid  (ex_valid),
  .ex_cond   (ex_cond),
  .ex_rs     (ex_rs),
  .ex_rt     (ex_rt),
  .br_taken  (br_taken),
  .br_target (br_target),
  .fetch_pc  (fetch_pc),
  .redirect  (redirect)
);

// File: tb/brx_resolve_unit_tb.sv
module brx_resolve_unit_tb;
  localparam logic [31:0] RV = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_valid = 1'b0;
  logic [2:0]  ex_cond = '0;
  logic [31:0] ex_pc = '0;
  logic [15:0] ex_offset = '0;
  logic [4:0]  ex_rs = '0;
  logic [4:0]  ex_rt = '0;
  logic [31:0] rs_rf_data = '0;
  logic [31:0] rt_rf_data = '0;
  logic        prev_wr_en = 1'b0;
  logic [4:0]  prev_rd = '0;
  logic [31:0] prev_result = '0;
  logic        br_taken;
  logic [31:0] br_target;
  logic [31:0] fetch_pc;
  logic        redirect;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_pc;
  logic [32:0] sb_q[$];

  always #4 clk = ~clk;

  brx_resolve_unit #(.RESET_VEC(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_cond(ex_cond),
    .ex_pc(ex_pc), .ex_offset(ex_offset), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .rs_rf_data(rs_rf_data), .rt_rf_data(rt_rf_data), .prev_wr_en(prev_wr_en),
    .prev_rd(prev_rd), .prev_result(prev_result), .br_taken(br_taken),
    .br_target(br_target), .fetch_pc(fetch_pc), .redirect(redirect)
  );

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] opv(input logic [4:0] idx, input logic [31:0] rf,
                                      input logic pw, input logic [4:0] prd,
                                      input logic [31:0] pres);
    if (idx == 5'd0) return 32'd0;
    if (pw && prd == idx) return pres;
    return rf;
  endfunction

  // Driver: applies one execute-cycle, checks the same-cycle decision (R10),
  // and pushes the expected fetch state after the next edge to the scoreboard.
  task automatic step(input logic v, input logic [2:0] c, input logic [31:0] pc,
                      input logic [15:0] off, input logic [4:0] rs, input logic [4:0] rt,
                      input logic [31:0] rsv, input logic [31:0] rtv, input logic pw,
                      input logic [4:0] prd, input logic [31:0] pres, input string req);
    logic [31:0] a, b, tgt;
    logic tk;
    ex_valid = v; ex_cond = c; ex_pc = pc; ex_offset = off; ex_rs = rs; ex_rt = rt;
    rs_rf_data = rsv; rt_rf_data = rtv; prev_wr_en = pw; prev_rd = prd; prev_result = pres;
    a = opv(rs, rsv, pw, prd, pres);
    b = opv(rt, rtv, pw, prd, pres);
    case (c)
      3'd0: tk = (a == b);
      3'd1: tk = (a != b);
      3'd2: tk = a[31];
      3'd3: tk = !a[31];
      3'd4: tk = a[31] || (a == 0);
      3'd5: tk = !a[31] && (a != 0);
      default: tk = 1'b0;
    endcase
    tk  = tk && v;
    tgt = pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    #1;
    chk({req, " R10 decision"}, {32'd0, br_taken}, {32'd0, tk});
    if (v) chk({req, " R6 target"}, {1'b0, br_target}, {1'b0, tgt});
    exp_pc = tk ? tgt : exp_pc + 32'd4;
    sb_q.push_back({tk, exp_pc});
    @(negedge clk);
  endtask

  // Monitor: compares fetch state shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      logic [32:0] e;
      e = sb_q.pop_front();
      chk(e[32] ? "R7 redirect to target" : "R2 sequential fetch",
          {redirect, fetch_pc}, e);
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset in hold", {redirect, fetch_pc}, {1'b0, RV});
    rst_n = 1'b1;
    #1;
    chk("R1 after release", {redirect, fetch_pc}, {1'b0, RV});
    exp_pc = RV;
    @(negedge clk);
    exp_pc = fetch_pc; // one edge elapsed unchecked; resync from R1-checked start
    chk("R2 first advance", {1'b0, fetch_pc}, {1'b0, RV + 32'd4});

    // R2: idle cycles, and a condition that would be taken with ex_valid low
    step(0, 3'd0, 32'h100, 16'h4, 5'd0, 5'd0, 0, 0, 0, 5'd0, 0, "R2 idle");
    step(0, 3'd0, 32'h100, 16'h4, 5'd0, 5'd0, 0, 0, 0, 5'd0, 0, "R2 idle eq");
    // R3 equal taken, positive offset
    step(1, 3'd0, 32'h1000, 16'h0010, 5'd3, 5'd4, 32'h55, 32'h55, 0, 5'd0, 0, "R3 eq");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 one-cycle redirect");
    // R3 not-equal with equal values
    step(1, 3'd1, 32'h2000, 16'h0020, 5'd3, 5'd4, 32'h9, 32'h9, 0, 5'd0, 0, "R3 ne");
    // R8 bypass: rf says positive, previous result negative, LTZ, negative offset
    step(1, 3'd2, 32'h3000, 16'hFFF0, 5'd6, 5'd1, 32'h5, 32'h0, 1, 5'd6, 32'hFFFF_FFFB, "R8 R4 ltz bypass");
    // R8 with write enable low: rf used
    step(1, 3'd2, 32'h3000, 16'hFFF0, 5'd6, 5'd1, 32'h5, 32'h0, 0, 5'd6, 32'hFFFF_FFFB, "R8 no bypass");
    // R8 bypass on second operand for EQ
    step(1, 3'd0, 32'h4000, 16'h0001, 5'd2, 5'd7, 32'h77, 32'h12, 1, 5'd7, 32'h77, "R8 rt bypass");
    // R4 zero value across sign/zero tests, second operand ignored
    step(1, 3'd3, 32'h5000, 16'h0002, 5'd8, 5'd9, 32'h0, 32'hFFFF_FFFF, 0, 5'd0, 0, "R4 gez zero");
    step(1, 3'd4, 32'h5100, 16'h0003, 5'd8, 5'd9, 32'h0, 32'h1, 0, 5'd0, 0, "R4 lez zero");
    step(1, 3'd5, 32'h5200, 16'h0004, 5'd8, 5'd9, 32'h0, 32'h1, 0, 5'd0, 0, "R4 gtz zero");
    step(1, 3'd5, 32'h5300, 16'h0005, 5'd8, 5'd9, 32'h1, 32'h0, 0, 5'd0, 0, "R4 gtz pos");
    step(1, 3'd4, 32'h5400, 16'h0006, 5'd8, 5'd9, 32'h8000_0000, 32'h0, 0, 5'd0, 0, "R4 lez neg");
    step(1, 3'd3, 32'h5500, 16'h0007, 5'd8, 5'd9, 32'h8000_0000, 32'h8000_0000, 0, 5'd0, 0, "R4 gez neg");
    // R5 reserved codes with equal operands
    step(1, 3'd6, 32'h6000, 16'h0008, 5'd3, 5'd3, 32'h1, 32'h1, 0, 5'd0, 0, "R5 code6");
    step(1, 3'd7, 32'h6000, 16'h0008, 5'd0, 5'd0, 32'h0, 32'h0, 0, 5'd0, 0, "R5 code7");
    // R9 register 0 with garbage rf and bypass to rd 0
    step(1, 3'd0, 32'h7000, 16'h0009, 5'd0, 5'd0, 32'h1234, 32'h5678, 1, 5'd0, 32'hDEAD, "R9 eq r0");
    step(1, 3'd2, 32'h7100, 16'h000A, 5'd0, 5'd1, 32'hFFFF_FFFF, 32'h0, 1, 5'd0, 32'hFFFF_FFFF, "R9 ltz r0");
    // R7 back-to-back taken branches
    step(1, 3'd1, 32'h8000, 16'h0100, 5'd1, 5'd2, 32'h1, 32'h2, 0, 5'd0, 0, "R7 b2b first");
    step(1, 3'd1, 32'h8404, 16'hFF00, 5'd1, 5'd2, 32'h1, 32'h2, 0, 5'd0, 0, "R7 b2b second");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 after taken");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 tail");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule